// File: doc/BRIEF.md
# Half to Single Precision Float Widener

This block widens a 16-bit half-precision floating-point value into a 32-bit single-precision word. It decodes the input into one of six classes (zero, subnormal, normal, infinity, quiet NaN, signalling NaN) and builds the wider encoding for that class. Every finite half value fits exactly in the wider format, so no rounding logic is present. A subnormal input is renormalised: its leading one sets the output exponent.

Three controls shape the result. An alternate-range select turns the all-ones exponent into an ordinary binade instead of infinity or NaN. A canonical-NaN select replaces any NaN with a single fixed quiet NaN. An eight-bit trap-enable vector decides whether a raised exception becomes a sticky status flag or a trap request. Results are registered: a sample taken with `in_valid` appears one clock later with `out_valid`.

Top module: `hcvt_half2single`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid`, `out_word`, `exc_flags` and `trap_req` are all cleared to zero at that edge.
- R2: A sample presented with `in_valid` high gives `out_valid` high on the next clock. After a cycle with `in_valid` low, `out_valid`, `exc_flags` and `trap_req` are zero.
- R3: An input with exponent field (bits 14:10) zero and fraction field (bits 9:0) zero yields a zero carrying the input sign in bit 31.
- R4: An input with exponent 1..30 yields sign in bit 31, exponent field (bits 30:23) equal to the input exponent plus 112, and fraction field (bits 22:0) equal to the input fraction shifted left by 13.
- R5: An input with exponent zero and nonzero fraction (value fraction × 2^-24) is normalised. With p the index of its highest set fraction bit, the output exponent is p + 103 and the output fraction holds the bits below p, left-aligned.
- R6: With the alternate range off, exponent 31 with zero fraction yields 0x7F800000, or 0xFF800000 when the sign is set.
- R7: With the alternate range off and canonical NaN off, exponent 31 with nonzero fraction yields the sign in bit 31, OR 0x7FC00000, OR input fraction bits 8:0 placed at bits 21:13.
- R8: With the alternate range off and canonical NaN on, every NaN input yields 0x7FC00000, whatever its sign and payload.
- R9: With the alternate range on, exponent 31 is converted as a normal number. The output exponent is 143, the fraction is widened as in R4, and no exception is raised.
- R10: A NaN whose fraction bit 9 is clear is signalling and raises invalid (code 0). When `trap_en[0]` is 0 it sets `exc_flags[0]`. When `trap_en[0]` is 1 it asserts `trap_req` instead and leaves `exc_flags[0]` clear. A quiet NaN (fraction bit 9 set) raises nothing.
- R11: No input raises any exception other than invalid. `exc_flags[7:1]` stay zero, and the enables `trap_en[7:1]` never cause `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_half | input | 16 | Half-precision operand |
| alt_range | input | 1 | Treat exponent 31 as an ordinary binade |
| canon_nan | input | 1 | Replace every NaN with 0x7FC00000 |
| trap_en | input | 8 | Trap enable per exception code (bit k for code k) |
| out_valid | output | 1 | Result present |
| out_word | output | 32 | Single-precision result |
| exc_flags | output | 8 | Sticky exception bits to OR into status (bit k for code k) |
| trap_req | output | 1 | An enabled exception was raised |

## Verification
Two functions can land in the same cycle. One is building the NaN result word under the canonical-NaN and payload rules. The other is routing the invalid exception to either a status flag or a trap request. The bench provokes the overlap by sending signalling NaNs under every mix of canonical-NaN and trap-enable settings. This includes enable vectors in which only unrelated bits are set. For each such sample, the word, the flag vector and the trap line are each compared against a behavioural model in the same output cycle. A full sweep of all 65536 encodings, and a strided sweep with mixed controls, cover the other class boundaries.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fclass_t;

  localparam int N_EXC       = 8;
  localparam int EXC_INVALID = 0;
  localparam int EXC_DIVZERO = 1;
  localparam int EXC_OVERFLW = 2;
  localparam int EXC_UNDERFL = 3;
  localparam int EXC_INEXACT = 4;
  localparam int EXC_INDENRM = 7;
endpackage

// File: rtl/hcvt_classify.sv
module hcvt_classify
  import hcvt_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              alt_range_i,
  output fclass_t           cls_o
);
  localparam logic [EXP_W-1:0] EXP_TOP = {EXP_W{1'b1}};

  logic exp_zero, exp_full, frac_zero, quiet_bit;

  assign exp_zero  = (exp_i == '0);
  assign exp_full  = (exp_i == EXP_TOP);
  assign frac_zero = (frac_i == '0);
  assign quiet_bit = frac_i[FRAC_W-1];

  always_comb begin
    if (exp_zero) begin
      cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    end else if (exp_full && !alt_range_i) begin
      if (frac_zero)      cls_o = CLS_INF;
      else if (quiet_bit) cls_o = CLS_QNAN;
      else                cls_o = CLS_SNAN;
    end else begin
      cls_o = CLS_NORM;
    end
  end
endmodule

// File: rtl/hcvt_subnorm.sv
module hcvt_subnorm #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 23,
  parameter int POS_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]  frac_i,
  output logic [POS_W-1:0] lead_o,
  output logic [OUT_W-1:0] frac_o
);
  logic [OUT_W:0] aligned;
  logic [IN_W-1:0] hit;

  // highest set bit wins: later (higher) indices overwrite earlier ones
  genvar g;
  generate
    for (g = 0; g < IN_W; g++) begin : g_hit
      assign hit[g] = frac_i[g];
    end
  endgenerate

  always_comb begin
    lead_o = '0;
    for (int k = 0; k < IN_W; k++) begin
      if (hit[k]) lead_o = POS_W'(k);
    end
  end

  // move the leading one to bit OUT_W, then drop it
  always_comb begin
    aligned = (OUT_W+1)'(frac_i) << (OUT_W - int'(lead_o));
    frac_o  = aligned[OUT_W-1:0];
  end
endmodule

// File: rtl/hcvt_except.sv
module hcvt_except #(
  parameter int NEXC = 8
) (
  input  logic [NEXC-1:0] raise_i,
  input  logic [NEXC-1:0] trap_en_i,
  output logic [NEXC-1:0] flags_o,
  output logic            trap_o
);
  logic [NEXC-1:0] taken;

  genvar k;
  generate
    for (k = 0; k < NEXC; k++) begin : g_route
      assign taken[k]   = raise_i[k] & trap_en_i[k];
      assign flags_o[k] = raise_i[k] & ~trap_en_i[k];
    end
  endgenerate

  assign trap_o = |taken;
endmodule

// File: rtl/hcvt_half2single.sv
module hcvt_half2single
  import hcvt_pkg::*;
#(
  parameter int HEXP_W  = 5,
  parameter int HFRAC_W = 10,
  parameter int SEXP_W  = 8,
  parameter int SFRAC_W = 23
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [HEXP_W+HFRAC_W:0]      in_half,
  input  logic                         alt_range,
  input  logic                         canon_nan,
  input  logic [N_EXC-1:0]             trap_en,
  output logic                         out_valid,
  output logic [SEXP_W+SFRAC_W:0]      out_word,
  output logic [N_EXC-1:0]             exc_flags,
  output logic                         trap_req
);
  localparam int HW       = HEXP_W + HFRAC_W + 1;
  localparam int SW       = SEXP_W + SFRAC_W + 1;
  localparam int HBIAS    = (1 << (HEXP_W - 1)) - 1;
  localparam int SBIAS    = (1 << (SEXP_W - 1)) - 1;
  localparam int EXP_ADJ  = SBIAS - HBIAS;
  localparam int SUB_EXP  = SBIAS - HBIAS - HFRAC_W + 1;
  localparam int FSHIFT   = SFRAC_W - HFRAC_W;
  localparam int POS_W    = $clog2(HFRAC_W);
  localparam int PAY_W    = HFRAC_W - 1;
  localparam logic [SEXP_W-1:0] SEXP_TOP = {SEXP_W{1'b1}};

  logic                 h_sign;
  logic [HEXP_W-1:0]    h_exp;
  logic [HFRAC_W-1:0]   h_frac;
  fclass_t              cls;
  logic [POS_W-1:0]     lead;
  logic [SFRAC_W-1:0]   sub_frac;
  logic [SW-1:0]        word_c;
  logic [N_EXC-1:0]     raise_c, flags_c;
  logic                 trap_c;

  assign h_sign = in_half[HW-1];
  assign h_exp  = in_half[HW-2:HFRAC_W];
  assign h_frac = in_half[HFRAC_W-1:0];

  hcvt_classify #(.EXP_W(HEXP_W), .FRAC_W(HFRAC_W)) u_cls (
    .exp_i       (h_exp),
    .frac_i      (h_frac),
    .alt_range_i (alt_range),
    .cls_o       (cls)
  );

  hcvt_subnorm #(.IN_W(HFRAC_W), .OUT_W(SFRAC_W), .POS_W(POS_W)) u_sub (
    .frac_i (h_frac),
    .lead_o (lead),
    .frac_o (sub_frac)
  );

  // result word per class
  always_comb begin
    unique case (cls)
      CLS_ZERO: word_c = {h_sign, {(SW-1){1'b0}}};
      CLS_SUB:  word_c = {h_sign, SEXP_W'(int'(lead) + SUB_EXP), sub_frac};
      CLS_INF:  word_c = {h_sign, SEXP_TOP, {SFRAC_W{1'b0}}};
      CLS_QNAN, CLS_SNAN: begin
        if (canon_nan)
          word_c = {1'b0, SEXP_TOP, 1'b1, {(SFRAC_W-1){1'b0}}};
        else
          word_c = {h_sign, SEXP_TOP, 1'b1, h_frac[PAY_W-1:0],
                    {(SFRAC_W-1-PAY_W){1'b0}}};
      end
      default:  word_c = {h_sign, SEXP_W'(int'(h_exp) + EXP_ADJ),
                          h_frac, {FSHIFT{1'b0}}};
    endcase
  end

  always_comb begin
    raise_c              = '0;
    raise_c[EXC_INVALID] = (cls == CLS_SNAN);
  end

  hcvt_except #(.NEXC(N_EXC)) u_exc (
    .raise_i   (raise_c),
    .trap_en_i (trap_en),
    .flags_o   (flags_c),
    .trap_o    (trap_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      exc_flags <= '0;
      trap_req  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= word_c;
        exc_flags <= flags_c;
        trap_req  <= trap_c;
      end else begin
        exc_flags <= '0;
        trap_req  <= 1'b0;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && exc_flags == '0 && !trap_req));

  // R10
  flag_or_trap_chk: assert property (@(posedge clk) disable iff (rst)
    !(trap_req && exc_flags[EXC_INVALID]));

  // R11
  only_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    exc_flags[N_EXC-1:1] == '0);

  // R6
  inf_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !alt_range && h_exp == '1 && h_frac == '0)
      |=> out_word[SW-2:0] == {SEXP_TOP, {SFRAC_W{1'b0}}});

  // R9
  alt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && alt_range) |=> (exc_flags == '0 && !trap_req));

  // R10
  snan_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !alt_range && h_exp == '1 && h_frac != '0 && !h_frac[HFRAC_W-1])
      |=> (trap_req || exc_flags[EXC_INVALID]));
endmodule

// File: tb/hcvt_half2single_test.sv
module hcvt_half2single_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] in_half;
  logic        alt_range, canon_nan;
  logic [7:0]  trap_en;
  logic        out_valid;
  logic [31:0] out_word;
  logic [7:0]  exc_flags;
  logic        trap_req;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // pending expectation for the next output cycle
  logic        p_v;
  logic [31:0] p_w;
  logic [7:0]  p_f;
  logic        p_t;
  string       p_wtag, p_ftag;

  always #4 clk = ~clk;

  hcvt_half2single uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .alt_range(alt_range), .canon_nan(canon_nan), .trap_en(trap_en),
    .out_valid(out_valid), .out_word(out_word), .exc_flags(exc_flags),
    .trap_req(trap_req)
  );

  task automatic model(input logic [15:0] h, input logic a, input logic d,
                       input logic [7:0] te, output logic [31:0] w,
                       output logic [7:0] f, output logic t,
                       output string wt, output string ft);
    logic s;
    int e, m, p;
    logic [23:0] ext;
    s = h[15]; e = int'(h[14:10]); m = int'(h[9:0]);
    f = 8'h00; t = 1'b0; ft = "R11";
    if (e == 0 && m == 0) begin
      w = {s, 31'b0}; wt = "R3";
    end else if (e == 0) begin
      p = 9;
      while (((m >> p) & 1) == 0) p--;
      ext = 24'(m) << (23 - p);
      w = {s, 8'(p + 103), ext[22:0]}; wt = "R5";
    end else if (e == 31 && !a) begin
      if (m == 0) begin
        w = {s, 8'hFF, 23'b0}; wt = "R6";
      end else begin
        if (d) begin w = 32'h7FC00000; wt = "R8"; end
        else begin w = {s, 8'hFF, 1'b1, h[8:0], 13'b0}; wt = "R7"; end
        ft = "R10";
        if (!h[9]) begin
          if (te[0]) t = 1'b1; else f[0] = 1'b1;
        end
      end
    end else begin
      w = {s, 8'(e + 112), h[9:0], 13'b0};
      wt = (e == 31) ? "R9" : "R4";
    end
  endtask

  task automatic compare();
    checks++;
    if (out_valid !== p_v) begin
      failures++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, p_v);
    end
    if (p_v) begin
      checks++;
      if (out_word !== p_w) begin
        failures++;
        $display("FAIL %s word in=%h actual=%h expected=%h", p_wtag, in_half, out_word, p_w);
      end
      checks++;
      if (exc_flags !== p_f || trap_req !== p_t) begin
        failures++;
        $display("FAIL %s flags/trap actual=%h/%0b expected=%h/%0b",
                 p_ftag, exc_flags, trap_req, p_f, p_t);
      end
    end else begin
      checks++;
      if (exc_flags !== 8'h00 || trap_req !== 1'b0) begin
        failures++;
        $display("FAIL R2 idle flags/trap actual=%h/%0b expected=00/0", exc_flags, trap_req);
      end
    end
  endtask

  task automatic step(input logic v, input logic [15:0] h, input logic a,
                      input logic d, input logic [7:0] te);
    @(negedge clk);
    compare();
    in_valid = v; in_half = h; alt_range = a; canon_nan = d; trap_en = te;
    p_v = v;
    model(h, a, d, te, p_w, p_f, p_t, p_wtag, p_ftag);
  endtask

  task automatic check_reset();
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'h0 || exc_flags !== 8'h0 || trap_req !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset state actual=%0b/%h/%h/%0b expected=0/00000000/00/0",
               out_valid, out_word, exc_flags, trap_req);
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_half = '0; alt_range = 1'b0;
    canon_nan = 1'b0; trap_en = '0; p_v = 1'b0;
    repeat (3) @(negedge clk);
    check_reset();  // R1
    rst = 1'b0;

    // R3 zeros
    step(1, 16'h0000, 0, 0, 8'h00);
    step(1, 16'h8000, 0, 0, 8'h00);
    // R4 normals
    step(1, 16'h3C00, 0, 0, 8'h00);
    step(1, 16'hC000, 0, 0, 8'h00);
    step(1, 16'h7BFF, 0, 0, 8'h00);
    step(1, 16'h0400, 0, 0, 8'h00);
    // R5 subnormals
    step(1, 16'h0001, 0, 0, 8'h00);
    step(1, 16'h03FF, 0, 0, 8'h00);
    step(1, 16'h8200, 0, 0, 8'h00);
    // R6 infinities
    step(1, 16'h7C00, 0, 0, 8'h00);
    step(1, 16'hFC00, 0, 1, 8'hFF);
    // R7 payload NaNs, R10 signalling
    step(1, 16'h7E00, 0, 0, 8'h00);
    step(1, 16'hFDFF, 0, 0, 8'h00);
    step(1, 16'h7C01, 0, 0, 8'h00);
    // R8 canonical NaN
    step(1, 16'hFFFF, 0, 1, 8'h00);
    step(1, 16'hFC01, 0, 1, 8'h00);
    // R10 trap routing
    step(1, 16'h7D55, 0, 0, 8'h01);
    step(1, 16'h7D55, 0, 1, 8'h01);
    step(1, 16'h7D55, 0, 0, 8'hFE);
    step(1, 16'h7E01, 0, 0, 8'h01);
    // R9 alternate range
    step(1, 16'h7C00, 1, 0, 8'hFF);
    step(1, 16'hFFFF, 1, 1, 8'h01);
    step(1, 16'h7C01, 1, 0, 8'h00);
    // R2 idle gaps
    step(0, 16'h7C01, 0, 0, 8'h00);
    step(1, 16'h7C01, 0, 0, 8'h00);
    step(0, 16'h0000, 0, 0, 8'h00);

    // R1 reset while busy
    step(1, 16'h7C01, 0, 0, 8'h01);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset();
    rst = 1'b0; in_valid = 1'b0; p_v = 1'b0;

    // full sweep, plain controls (R3..R7, R10, R11)
    for (int i = 0; i < 65536; i++) begin
      step(1, 16'(i), 0, 0, 8'h00);
      if ((i % 997) == 0) step(0, 16'(i), 0, 0, 8'h00);
    end
    // strided sweep, mixed controls (R8, R9, R10, R11)
    for (int i = 0; i < 65536; i += 5) begin
      step(1, 16'(i), (i >> 4) & 1, (i >> 5) & 1, 8'((i >> 6) * 37));
    end
    step(0, 16'h0000, 0, 0, 8'h00);
    step(0, 16'h0000, 0, 0, 8'h00);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule